// File: doc/BRIEF.md
# SPI Boot Kernel Loader

This block runs once after reset and copies a fixed-size boot kernel from an external serial flash into on-chip memory. It acts as the SPI master and needs no host control. It lowers its device-select line and then clocks out a read opcode followed by a zero start address. After that it keeps the serial clock running and collects the returned bits into 32-bit words.

Each completed word appears on a simple write port as a one-cycle strobe. The strobe carries the word and an on-chip address, which starts at a fixed base and steps by one per word. After the preset number of words, the loader releases the flash, parks the clock high and raises a done flag. The flag stays high until the next reset.

The serial clock uses SPI mode 3. It idles high, data changes on the falling (leading) edge and data is sampled on the rising (trailing) edge. The clock period is a parameter in system clocks.

Top module: `spi_boot_loader`

## Requirements
- R1: During reset the outputs are: `spi_cs_n` high, `spi_sclk` high, `spi_mosi` low, `boot_done` low and `mem_wr_valid` low.
- R2: `spi_cs_n` is low for at least one system clock before the first falling edge of `spi_sclk`.
- R3: The first 32 bits on `spi_mosi` are the opcode 0x03 followed by 24 zero address bits, most significant bit first. `spi_mosi` changes only in the cycle where `spi_sclk` falls.
- R4: `spi_sclk` is high whenever `spi_cs_n` is high. While running, its period is `SCLK_DIV` system clocks (even, at least 4): low for `SCLK_DIV/2` clocks, then high for `SCLK_DIV/2` clocks.
- R5: `spi_miso` is sampled on each rising `spi_sclk` edge after the preamble. Each group of 32 samples forms one word, most significant bit first. The first sample of a group lands in bit 31.
- R6: Each word is delivered by a single-cycle `mem_wr_valid` pulse. Word k is written to address `MEM_BASE + k`, with `MEM_BASE` = 0x0008_0000 by default.
- R7: Exactly `WORD_COUNT` words are written (default 384, 0x180).
- R8: `boot_done` rises in the cycle of the last write strobe and holds until reset. From that cycle on, `spi_cs_n` and `spi_sclk` are high and no further strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; starts the boot sequence when released |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_cs_n | output | 1 | Active-low flash select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| mem_wr_valid | output | 1 | One-cycle write strobe |
| mem_wr_addr | output | 32 | On-chip word address of the write |
| mem_wr_data | output | 32 | Assembled 32-bit word |
| boot_done | output | 1 | High once every word has been written |

## Verification
The checker watches the following on every cycle:
- the clock stays parked high while the flash is deselected;
- data changes only on falling clock edges;
- each divider pulse moves the clock in the correct direction;
- a word boundary leads to a single-cycle strobe;
- the address steps by exactly one from the base;
- the strobe count never exceeds the limit;
- the done flag is sticky.

Other properties can only be shown by the bench's scenarios, which play a flash model against the loader over two resets with different data:
- the exact preamble bit sequence;
- the measured clock period and duty;
- the bit order of the assembled words;
- the exact total number of writes.

// File: rtl/sbl_pkg.sv
package sbl_pkg;

  typedef enum logic [1:0] {
    ST_SELECT = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_FINISH = 2'd2
  } sbl_state_e;

  // Bit idx of the outgoing preamble: opcode first, then all-zero address.
  function automatic logic preamble_bit(logic [7:0] opcode, int unsigned idx);
    if (idx < 8) return opcode[7 - idx];
    return 1'b0;
  endfunction

  // True when serial bit number b is the last bit of a received word.
  function automatic logic is_word_end(int unsigned b, int unsigned pre_bits);
    if (b < pre_bits) return 1'b0;
    return ((b - pre_bits) % 32) == 31;
  endfunction

  function automatic logic [31:0] word_addr(logic [31:0] base, int unsigned k);
    return base + 32'(k);
  endfunction

endpackage

// File: rtl/sbl_clkgen.sv
module sbl_clkgen #(
  parameter int unsigned SCLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic lead,
  output logic trail
);
  localparam int unsigned CW   = (SCLK_DIV > 2) ? $clog2(SCLK_DIV) : 1;
  localparam int unsigned HALF = SCLK_DIV / 2;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (!en)                       cnt_q <= '0;
    else if (cnt_q == CW'(SCLK_DIV-1))  cnt_q <= '0;
    else                                cnt_q <= cnt_q + 1'b1;
  end

  assign lead  = en && (cnt_q == '0);
  assign trail = en && (cnt_q == CW'(HALF));
endmodule

// File: rtl/sbl_shifter.sv
module sbl_shifter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word <= '0;
    else if (sample) word <= {word[W-2:0], bit_in};
  end
endmodule

// File: rtl/sbl_seq.sv
module sbl_seq
  import sbl_pkg::*;
#(
  parameter logic [7:0]  OPCODE     = 8'h03,
  parameter int unsigned ADDR_BYTES = 3,
  parameter int unsigned WORD_COUNT = 384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lead,
  input  logic trail,
  output logic run,
  output logic sample,
  output logic word_end,
  output logic cs_n,
  output logic sclk,
  output logic mosi,
  output logic done
);
  localparam int unsigned PRE_BITS = 8 + 8 * ADDR_BYTES;
  localparam int unsigned TOTAL    = PRE_BITS + 32 * WORD_COUNT;
  localparam int unsigned BW       = $clog2(TOTAL + 1);

  sbl_state_e    st_q;
  logic [BW-1:0] bit_q;

  assign run      = (st_q == ST_SHIFT);
  assign sample   = run && trail && (32'(bit_q) >= PRE_BITS);
  assign word_end = run && trail && is_word_end(32'(bit_q), PRE_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_SELECT;
      bit_q <= '0;
      cs_n  <= 1'b1;
      sclk  <= 1'b1;
      mosi  <= 1'b0;
      done  <= 1'b0;
    end else begin
      case (st_q)
        ST_SELECT: begin
          cs_n <= 1'b0;
          st_q <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (lead) begin
            sclk <= 1'b0;
            mosi <= (32'(bit_q) < PRE_BITS) ? preamble_bit(OPCODE, 32'(bit_q)) : 1'b0;
          end
          if (trail) begin
            sclk  <= 1'b1;
            bit_q <= bit_q + 1'b1;
            if (bit_q == BW'(TOTAL - 1)) begin
              st_q <= ST_FINISH;
              cs_n <= 1'b1;
              done <= 1'b1;
            end
          end
        end
        default: begin
          cs_n <= 1'b1;
          sclk <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_boot_loader.sv
module spi_boot_loader
  import sbl_pkg::*;
#(
  parameter int unsigned SCLK_DIV   = 4,
  parameter int unsigned WORD_COUNT = 384,
  parameter logic [31:0] MEM_BASE   = 32'h0008_0000,
  parameter logic [7:0]  OPCODE     = 8'h03
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        mem_wr_valid,
  output logic [31:0] mem_wr_addr,
  output logic [31:0] mem_wr_data,
  output logic        boot_done
);
  localparam int unsigned KW = $clog2(WORD_COUNT + 1);

  // Internal events brought out by name for the checker.
  logic lead_ev, trail_ev, word_ev, run, sample;
  logic [KW-1:0] widx_q;

  sbl_clkgen #(.SCLK_DIV(SCLK_DIV)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .en(run), .lead(lead_ev), .trail(trail_ev)
  );

  sbl_seq #(.OPCODE(OPCODE), .ADDR_BYTES(3), .WORD_COUNT(WORD_COUNT)) seq_i (
    .clk(clk), .rst_n(rst_n), .lead(lead_ev), .trail(trail_ev),
    .run(run), .sample(sample), .word_end(word_ev),
    .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi), .done(boot_done)
  );

  sbl_shifter #(.W(32)) shift_i (
    .clk(clk), .rst_n(rst_n), .sample(sample), .bit_in(spi_miso), .word(mem_wr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_wr_valid <= 1'b0;
      widx_q       <= '0;
    end else begin
      mem_wr_valid <= word_ev;
      if (mem_wr_valid) widx_q <= widx_q + 1'b1;
    end
  end

  assign mem_wr_addr = word_addr(MEM_BASE, 32'(widx_q));
endmodule

// File: rtl/sbl_checker.sv
module sbl_checker #(
  parameter int unsigned WORD_COUNT = 384,
  parameter logic [31:0] MEM_BASE   = 32'h0008_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        spi_sclk,
  input logic        spi_cs_n,
  input logic        spi_mosi,
  input logic        mem_wr_valid,
  input logic [31:0] mem_wr_addr,
  input logic        boot_done,
  input logic        lead_ev,
  input logic        trail_ev,
  input logic        word_ev
);
  logic        seen_q;
  logic [31:0] last_addr_q;
  int unsigned nwr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q      <= 1'b0;
      last_addr_q <= '0;
      nwr_q       <= 0;
    end else if (mem_wr_valid) begin
      seen_q      <= 1'b1;
      last_addr_q <= mem_wr_addr;
      nwr_q       <= nwr_q + 1;
    end
  end

  p_cs_before_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_sclk) |-> $past(spi_cs_n) == 1'b0);
  p_mosi_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_mosi) |-> $fell(spi_sclk));
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> spi_sclk);
  p_lead_falls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lead_ev |=> !spi_sclk);
  p_trail_rises_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trail_ev |=> spi_sclk);
  p_word_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_ev |=> mem_wr_valid);
  p_strobe_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |=> !mem_wr_valid);
  p_first_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !seen_q |-> mem_wr_addr == MEM_BASE);
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && seen_q |-> mem_wr_addr == last_addr_q + 32'd1);
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> nwr_q < WORD_COUNT);
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done);
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> spi_cs_n && spi_sclk);
  p_no_write_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(boot_done) |-> !mem_wr_valid);
endmodule

bind spi_boot_loader sbl_checker #(.WORD_COUNT(WORD_COUNT), .MEM_BASE(MEM_BASE)) chk_i (
  .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
  .spi_mosi(spi_mosi), .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
  .boot_done(boot_done), .lead_ev(lead_ev), .trail_ev(trail_ev), .word_ev(word_ev)
);

// File: tb/spi_boot_loader_tb.sv
`timescale 1ns/1ps
module spi_boot_loader_tb_top;
  localparam int unsigned DIV  = 6;
  localparam int unsigned WC   = 5;
  localparam logic [31:0] BASE = 32'h0008_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miso = 1'b0;
  logic sclk, cs_n, mosi, wv, done;
  logic [31:0] waddr, wdata;

  always #5 clk = ~clk;

  spi_boot_loader #(.SCLK_DIV(DIV), .WORD_COUNT(WC), .MEM_BASE(BASE), .OPCODE(8'h03)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .mem_wr_valid(wv), .mem_wr_addr(waddr), .mem_wr_data(wdata),
    .boot_done(done)
  );

  int tests = 0;
  int fails = 0;
  int seed = 0;
  int falls = 0;
  int rises = 0;
  int nwr = 0;
  int bad_period = 0;
  logic [31:0] pre = '0;

  function automatic logic [31:0] exp_word(int s, int k);
    return (32'h9E37_79B9 * 32'(k + 1)) ^ (32'h0F1E_2D3C * 32'(s + 1));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Flash model: drives data on the falling clock edge once the 32-bit preamble is done.
  initial forever begin
    @(negedge sclk);
    if (cs_n === 1'b0) begin
      if (falls == 0) check("R2 cs low before first sclk fall", 32'(cs_n), 32'd0);
      if (falls >= 32) miso = exp_word(seed, (falls - 32) / 32)[31 - ((falls - 32) % 32)];
      falls++;
    end
  end

  // Preamble capture on rising edges.
  initial forever begin
    @(posedge sclk);
    if (cs_n === 1'b0) begin
      if (rises < 32) pre = {pre[30:0], mosi};
      rises++;
    end
  end

  // Cycle monitor, away from the active edge.
  initial begin
    logic prev = 1'b1;
    int cyc = 0, last_fall = -1;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n && cs_n !== 1'b1) begin
        if (prev && !sclk) begin
          if (last_fall >= 0 && cyc - last_fall != DIV) bad_period++;
          last_fall = cyc;
        end
        if (!prev && sclk && cyc - last_fall != DIV / 2) bad_period++;
      end else last_fall = -1;
      prev = sclk;
      if (wv === 1'b1) begin
        check($sformatf("R6 address of word %0d", nwr), waddr, BASE + 32'(nwr));
        check($sformatf("R5 data of word %0d", nwr), wdata, exp_word(seed, nwr));
        if (nwr == WC - 1) check("R8 done rises with last strobe", 32'(done), 32'd1);
        nwr++;
      end
    end
  end

  task automatic one_run(int s);
    int c;
    rst_n = 1'b0;
    seed = s;
    falls = 0; rises = 0; nwr = 0; bad_period = 0; pre = '0; miso = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset cs_n", 32'(cs_n), 32'd1);
    check("R1 reset sclk", 32'(sclk), 32'd1);
    check("R1 reset mosi/done/valid", {29'd0, mosi, done, wv}, 32'd0);
    rst_n = 1'b1;
    c = 0;
    while (done !== 1'b1 && c < 20000) begin
      @(negedge clk);
      c++;
    end
    if (done !== 1'b1) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", c);
    end
    check("R3 preamble bits", pre, 32'h0300_0000);
    check("R4 sclk period and duty", 32'(bad_period), 32'd0);
    check("R4 sclk edge count", 32'(falls), 32'(32 + 32 * WC));
    repeat (40) @(negedge clk);
    check("R7 write count", 32'(nwr), 32'(WC));
    check("R8 done held", 32'(done), 32'd1);
    check("R8 cs_n and sclk high after done", {30'd0, cs_n, sclk}, 32'd3);
  endtask

  initial begin
    one_run(0);
    one_run(7);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule